// File: doc/BRIEF.md
# Batching Bank-Parallel Request Scheduler

This block chooses which buffered DRAM request goes to the device next. Requests from several threads enter a small fixed-size buffer through a valid/ready enqueue port. Each request carries a thread number, a target bank and a target row. The scheduler makes at most one choice per cycle. It reports the choice as a buffer slot index, and that slot is released at the following clock edge.

Starvation is bounded by grouping work into batches. When the buffer holds requests and none of them is in a batch, the scheduler spends one cycle forming a new batch. In that cycle it tags, for every thread and bank pair, the oldest requests up to a programmable cap. It also ranks the threads once. A thread whose busiest bank holds the fewest tagged requests ranks best. Ties go to the lower total of tagged requests, and then to the lower thread number. A thread's requests are therefore served close together in time and spread across its banks.

Tagged requests always win over untagged ones. A bank that holds no tagged request may still serve untagged work, so no bandwidth is wasted. A cap of zero turns batching off, and every request is then handled as if it were tagged. The enqueue port stalls only while the buffer is full. Its producer must hold the request fields steady while `enq_valid` is high and `enq_ready` is low.

Top module: `pbs_scheduler`

## Requirements
- R1: A request is accepted on a cycle where `enq_valid` and `enq_ready` are both high. It goes to the lowest-numbered free slot. `enq_ready` is low exactly when every slot is occupied.
- R2: With `mark_cap` = 0, no batch is formed, `batch_active` stays 0 and no idle formation cycle occurs. Requests are granted by row hit first, then by thread rank, then by age.
- R3: With `mark_cap` > 0, a formation cycle occurs when the buffer holds requests and none of them is tagged. In that cycle there is no grant. In every thread/bank group, the oldest requests up to `mark_cap` are tagged, and `batch_active` reads 1 from the next cycle. No new batch forms while a tagged request remains.
- R4: A request accepted after a batch has formed is not tagged into that batch. It cannot be granted at a bank that still holds a tagged request, even when it hits the open row.
- R5: At formation, each thread's rank is set from its tagged requests. A smaller maximum per-bank count ranks better, then a smaller total, then a lower thread number. Rank 0 is best. `thread_rank` field t (bits t*2+1..t*2 by default) gives thread t's rank, and the ranks form a permutation.
- R6: Among the eligible requests, the grant goes to a tagged request first, then to a row hit (bank open-row valid and row equal), then to the better-ranked thread, then to the oldest request.
- R7: While a batch is active, an untagged request may be granted at a bank that holds no tagged request.
- R8: A request is granted only if `bank_ready` for its bank is 1. `grant_valid` is 0 when nothing is eligible.
- R9: At most one grant is made per cycle. The granted slot is freed at the next edge and is never granted twice.
- R10: After reset, the buffer is empty, `enq_ready`=1, `grant_valid`=0 and `batch_active`=0, and thread t has rank t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue request present |
| enq_ready | output | 1 | A buffer slot is free |
| enq_thread | input | 2 | Thread number of the request |
| enq_bank | input | 2 | Target bank |
| enq_row | input | 8 | Target row |
| mark_cap | input | 3 | Per thread/bank batch cap; 0 disables batching |
| bank_ready | input | 4 | Bank may accept a command this cycle |
| bank_open_valid | input | 4 | Bank has an open row |
| bank_open_row | input | 32 | Open row per bank, bank b at bits b*8+7..b*8 |
| grant_valid | output | 1 | A request is granted this cycle |
| grant_idx | output | 3 | Slot index of the granted request |
| batch_active | output | 1 | Tagged requests remain in the buffer |
| thread_rank | output | 8 | Current rank per thread, 2 bits each |

## Verification
The grant is combinational from the registered buffer state and the bank inputs. A request accepted at one edge can therefore be granted in the cycle that follows that edge. With batching on, that cycle is instead the formation cycle, so tags, ranks and `batch_active` change one edge later and the first tagged grant shows in the cycle after. The bench drives every input on the falling edge and samples 1 ns later. Each slot index it expects is fixed by the R1 lowest-free-slot rule. The bench steps one cycle per expected grant, so each sample falls inside the cycle in which that grant is due.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  // Scheduler operating mode, derived each cycle from cap and buffer state
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,  // cap is zero: no batching
    MODE_FORM   = 2'd1,  // buffer holds work but nothing tagged: build batch
    MODE_RUN    = 2'd2   // serving a batch or idle
  } sched_mode_e;

  function automatic int min_w(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pbs_age_matrix.sv
module pbs_age_matrix
  import pbs_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = min_w(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_en,
  input  logic [IDX_W-1:0]              alloc_idx,
  input  logic [DEPTH-1:0]              valid,
  output logic [DEPTH-1:0][DEPTH-1:0]   older   // older[i][j]: slot i arrived before slot j
);

  logic [DEPTH-1:0][DEPTH-1:0] older_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (alloc_en) begin
      for (int j = 0; j < DEPTH; j++) begin
        older_q[alloc_idx][j] <= 1'b0;
        older_q[j][alloc_idx] <= valid[j];
      end
    end
  end

  assign older = older_q;

  // Any two live slots must be strictly ordered
  logic pair_ok;
  always_comb begin
    pair_ok = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      for (int j = 0; j < DEPTH; j++)
        if (i != j && valid[i] && valid[j] && (older_q[i][j] == older_q[j][i]))
          pair_ok = 1'b0;
  end

  assert_age_order_R6: assert property (@(posedge clk) disable iff (!rst_n) pair_ok);

endmodule

// File: rtl/pbs_mark_rank.sv
module pbs_mark_rank
  import pbs_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_BANKS   = 4,
  parameter int DEPTH       = 8,
  parameter int CAP_W       = 3,
  localparam int TID_W  = min_w(NUM_THREADS),
  localparam int BANK_W = min_w(NUM_BANKS),
  localparam int CNT_W  = min_w(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]                   valid,
  input  logic [DEPTH-1:0][TID_W-1:0]        thr,
  input  logic [DEPTH-1:0][BANK_W-1:0]       bank,
  input  logic [DEPTH-1:0][DEPTH-1:0]        older,
  input  logic [CAP_W-1:0]                   cap,
  output logic [DEPTH-1:0]                   mark_next,
  output logic [NUM_THREADS-1:0][TID_W-1:0]  rank_next
);

  logic [CNT_W-1:0] load [NUM_THREADS][NUM_BANKS];
  logic [CNT_W-1:0] peak [NUM_THREADS];
  logic [CNT_W-1:0] total [NUM_THREADS];

  // Tag a request when fewer than cap older ones share its thread and bank
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int ahead;
      ahead = 0;
      for (int j = 0; j < DEPTH; j++)
        if (j != i && valid[j] && older[j][i] && thr[j] == thr[i] && bank[j] == bank[i])
          ahead++;
      mark_next[i] = valid[i] && (ahead < int'(cap));
    end
  end

  // Per-thread, per-bank tagged load
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++)
      for (int b = 0; b < NUM_BANKS; b++) begin
        int n;
        n = 0;
        for (int i = 0; i < DEPTH; i++)
          if (mark_next[i] && int'(thr[i]) == t && int'(bank[i]) == b)
            n++;
        load[t][b] = CNT_W'(n);
      end
  end

  // Busiest-bank load and total load per thread
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      int mx;
      int sum;
      mx  = 0;
      sum = 0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        sum = sum + int'(load[t][b]);
        if (int'(load[t][b]) > mx)
          mx = int'(load[t][b]);
      end
      peak[t]  = CNT_W'(mx);
      total[t] = CNT_W'(sum);
    end
  end

  // Rank = number of threads that beat this one
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      int r;
      r = 0;
      for (int u = 0; u < NUM_THREADS; u++)
        if (u != t && (peak[u] < peak[t] ||
                       (peak[u] == peak[t] && (total[u] < total[t] ||
                                               (total[u] == total[t] && u < t)))))
          r++;
      rank_next[t] = TID_W'(r);
    end
  end

endmodule

// File: rtl/pbs_grant_arb.sv
module pbs_grant_arb
  import pbs_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_BANKS   = 4,
  parameter int DEPTH       = 8,
  parameter int ROW_W       = 8,
  localparam int TID_W  = min_w(NUM_THREADS),
  localparam int BANK_W = min_w(NUM_BANKS),
  localparam int IDX_W  = min_w(DEPTH),
  localparam int KEY_W  = TID_W + 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [DEPTH-1:0]                    valid,
  input  logic [DEPTH-1:0]                    cand_mark,
  input  logic [DEPTH-1:0][TID_W-1:0]         thr,
  input  logic [DEPTH-1:0][BANK_W-1:0]        bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]         row,
  input  logic [DEPTH-1:0][DEPTH-1:0]         older,
  input  logic [NUM_THREADS-1:0][TID_W-1:0]   rank,
  input  logic [NUM_BANKS-1:0]                bank_ready,
  input  logic [NUM_BANKS-1:0]                open_valid,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]     open_row,
  input  logic                                hold,
  output logic                                grant_valid,
  output logic [IDX_W-1:0]                    grant_idx
);

  logic [NUM_BANKS-1:0]        bank_has_mark;
  logic [DEPTH-1:0]            elig;
  logic [DEPTH-1:0]            win;
  logic [DEPTH-1:0][KEY_W-1:0] key;

  always_comb begin
    bank_has_mark = '0;
    for (int i = 0; i < DEPTH; i++)
      if (valid[i] && cand_mark[i])
        bank_has_mark[bank[i]] = 1'b1;
  end

  // Priority key: tagged, then row hit, then better (lower) rank
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic hit;
      hit     = open_valid[bank[i]] && (open_row[bank[i]] == row[i]);
      key[i]  = {cand_mark[i], hit, ~rank[thr[i]]};
      elig[i] = !hold && valid[i] && bank_ready[bank[i]] &&
                (cand_mark[i] || !bank_has_mark[bank[i]]);
    end
  end

  // A slot wins when no other eligible slot beats it; age breaks key ties
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic w;
      w = elig[i];
      for (int j = 0; j < DEPTH; j++)
        if (j != i && elig[j] &&
            (key[j] > key[i] || (key[j] == key[i] && older[j][i])))
          w = 1'b0;
      win[i] = w;
    end
  end

  always_comb begin
    grant_valid = |win;
    grant_idx   = '0;
    for (int i = 0; i < DEPTH; i++)
      if (win[i])
        grant_idx = IDX_W'(i);
  end

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(win));

  assert_grant_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (valid[grant_idx] && bank_ready[bank[grant_idx]]));

endmodule

// File: rtl/pbs_scheduler.sv
module pbs_scheduler
  import pbs_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_BANKS   = 4,
  parameter int DEPTH       = 8,
  parameter int ROW_W       = 8,
  parameter int CAP_W       = 3,
  localparam int TID_W  = min_w(NUM_THREADS),
  localparam int BANK_W = min_w(NUM_BANKS),
  localparam int IDX_W  = min_w(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enq_valid,
  output logic                          enq_ready,
  input  logic [TID_W-1:0]              enq_thread,
  input  logic [BANK_W-1:0]             enq_bank,
  input  logic [ROW_W-1:0]              enq_row,
  input  logic [CAP_W-1:0]              mark_cap,
  input  logic [NUM_BANKS-1:0]          bank_ready,
  input  logic [NUM_BANKS-1:0]          bank_open_valid,
  input  logic [NUM_BANKS*ROW_W-1:0]    bank_open_row,
  output logic                          grant_valid,
  output logic [IDX_W-1:0]              grant_idx,
  output logic                          batch_active,
  output logic [NUM_THREADS*TID_W-1:0]  thread_rank
);

  logic [DEPTH-1:0]                  valid_q;
  logic [DEPTH-1:0]                  mark_q;
  logic [DEPTH-1:0][TID_W-1:0]       thr_q;
  logic [DEPTH-1:0][BANK_W-1:0]      bank_q;
  logic [DEPTH-1:0][ROW_W-1:0]       row_q;
  logic [NUM_THREADS-1:0][TID_W-1:0] rank_q;

  logic [DEPTH-1:0][DEPTH-1:0]       older;
  logic [DEPTH-1:0]                  mark_next;
  logic [NUM_THREADS-1:0][TID_W-1:0] rank_next;
  logic [DEPTH-1:0]                  cand_mark;
  logic [DEPTH-1:0]                  live_marks;
  logic [NUM_BANKS-1:0][ROW_W-1:0]   open_row;
  logic [IDX_W-1:0]                  free_idx;
  logic                              alloc;
  logic                              any_mark;
  logic                              form;
  sched_mode_e                       mode;

  assign open_row   = bank_open_row;
  assign live_marks = valid_q & mark_q;
  assign any_mark   = |live_marks;
  assign enq_ready  = ~&valid_q;
  assign alloc      = enq_valid && enq_ready;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!valid_q[i])
        free_idx = IDX_W'(i);
  end

  always_comb begin
    if (mark_cap == '0)
      mode = MODE_BYPASS;
    else if ((|valid_q) && !any_mark)
      mode = MODE_FORM;
    else
      mode = MODE_RUN;
  end

  assign form         = (mode == MODE_FORM);
  assign cand_mark    = (mode == MODE_BYPASS) ? valid_q : live_marks;
  assign batch_active = (mode != MODE_BYPASS) && any_mark;
  assign thread_rank  = rank_q;

  pbs_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc),
    .alloc_idx (free_idx),
    .valid     (valid_q),
    .older     (older)
  );

  pbs_mark_rank #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_BANKS   (NUM_BANKS),
    .DEPTH       (DEPTH),
    .CAP_W       (CAP_W)
  ) u_mark (
    .valid     (valid_q),
    .thr       (thr_q),
    .bank      (bank_q),
    .older     (older),
    .cap       (mark_cap),
    .mark_next (mark_next),
    .rank_next (rank_next)
  );

  pbs_grant_arb #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_BANKS   (NUM_BANKS),
    .DEPTH       (DEPTH),
    .ROW_W       (ROW_W)
  ) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (valid_q),
    .cand_mark   (cand_mark),
    .thr         (thr_q),
    .bank        (bank_q),
    .row         (row_q),
    .older       (older),
    .rank        (rank_q),
    .bank_ready  (bank_ready),
    .open_valid  (bank_open_valid),
    .open_row    (open_row),
    .hold        (form),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      mark_q  <= '0;
      thr_q   <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      for (int t = 0; t < NUM_THREADS; t++)
        rank_q[t] <= TID_W'(t);
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (grant_valid && grant_idx == IDX_W'(i))
          valid_q[i] <= 1'b0;
        if (alloc && free_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          thr_q[i]   <= enq_thread;
          bank_q[i]  <= enq_bank;
          row_q[i]   <= enq_row;
        end
      end
      if (mode == MODE_BYPASS)
        mark_q <= '0;
      else if (form)
        mark_q <= mark_next;
      else if (alloc)
        mark_q[free_idx] <= 1'b0;
      if (form)
        rank_q <= rank_next;
    end
  end

  // Rank register always holds a permutation of thread numbers
  logic [NUM_THREADS-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int t = 0; t < NUM_THREADS; t++)
      rank_seen[rank_q[t]] = 1'b1;
  end

  assert_rank_perm_R5: assert property (@(posedge clk) disable iff (!rst_n) &rank_seen);

  assert_no_late_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> !mark_q[$past(free_idx)]);

  assert_no_regrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !form |=> ($countones(live_marks) <= $countones($past(live_marks))));

  assert_form_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    form |=> (batch_active || mark_cap == '0));

endmodule

// File: tb/pbs_scheduler_test.sv
module pbs_scheduler_test;

  localparam int NT = 4;
  localparam int NB = 4;
  localparam int DEPTH = 8;
  localparam int ROW_W = 8;
  localparam int CAP_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enq_valid = 1'b0;
  logic              enq_ready;
  logic [1:0]        enq_thread = '0;
  logic [1:0]        enq_bank = '0;
  logic [ROW_W-1:0]  enq_row = '0;
  logic [CAP_W-1:0]  mark_cap = '0;
  logic [NB-1:0]     bank_ready = '0;
  logic [NB-1:0]     bank_open_valid = '0;
  logic [NB*ROW_W-1:0] bank_open_row = '0;
  logic              grant_valid;
  logic [2:0]        grant_idx;
  logic              batch_active;
  logic [7:0]        thread_rank;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pbs_scheduler #(
    .NUM_THREADS (NT),
    .NUM_BANKS   (NB),
    .DEPTH       (DEPTH),
    .ROW_W       (ROW_W),
    .CAP_W       (CAP_W)
  ) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .enq_valid       (enq_valid),
    .enq_ready       (enq_ready),
    .enq_thread      (enq_thread),
    .enq_bank        (enq_bank),
    .enq_row         (enq_row),
    .mark_cap        (mark_cap),
    .bank_ready      (bank_ready),
    .bank_open_valid (bank_open_valid),
    .bank_open_row   (bank_open_row),
    .grant_valid     (grant_valid),
    .grant_idx       (grant_idx),
    .batch_active    (batch_active),
    .thread_rank     (thread_rank)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_grant(string tag, int idx);
    check(tag, {28'd0, grant_valid, grant_idx}, {28'd0, 1'b1, 3'(idx)});
  endtask

  task automatic enq(int t, int b, int r);
    @(negedge clk);
    enq_valid  = 1'b1;
    enq_thread = 2'(t);
    enq_bank   = 2'(b);
    enq_row    = 8'(r);
    @(posedge clk);
    #1 enq_valid = 1'b0;
  endtask

  task automatic test_reset;
    @(negedge clk);
    #1;
    check("R10 enq_ready after reset", 32'(enq_ready), 32'd1);
    check("R10 no grant after reset", 32'(grant_valid), 32'd0);
    check("R10 batch idle after reset", 32'(batch_active), 32'd0);
    check("R10 ranks equal thread ids", 32'(thread_rank), 32'hE4);
  endtask

  // Batch tagging, ranking and grant order under a full buffer
  task automatic test_batch_rank;
    int order[7] = '{5, 3, 4, 0, 1, 6, 7};
    mark_cap   = 3'd0;
    bank_ready = 4'h0;
    bank_open_valid = 4'h0;
    enq(0, 0, 1);
    enq(0, 0, 2);
    enq(0, 0, 3);
    enq(1, 1, 1);
    enq(1, 2, 1);
    enq(2, 0, 5);
    enq(3, 3, 1);
    check("R1 ready with one slot left", 32'(enq_ready), 32'd1);
    enq(3, 3, 2);
    @(negedge clk);
    mark_cap = 3'd2;
    #1;
    check("R1 enq_ready low when full", 32'(enq_ready), 32'd0);
    check("R3 formation cycle has no grant", 32'(grant_valid), 32'd0);
    @(negedge clk);
    bank_ready = 4'hF;
    #1;
    check("R3 batch_active after formation", 32'(batch_active), 32'd1);
    check("R5 ranks by max then total then id", 32'(thread_rank), 32'hC6);
    expect_grant("R6 best-ranked tagged first", order[0]);
    for (int k = 1; k < 7; k++) begin
      @(negedge clk);
      #1;
      expect_grant("R6 R9 tagged batch order", order[k]);
    end
    @(negedge clk);
    #1;
    check("R3 untagged left waits for next formation", 32'(grant_valid), 32'd0);
    check("R3 batch drained", 32'(batch_active), 32'd0);
    @(negedge clk);
    #1;
    expect_grant("R3 leftover tagged in new batch", 2);
    check("R5 ranks after second formation", 32'(thread_rank), 32'h93);
    @(negedge clk);
    #1;
    check("R9 buffer empty after drain", 32'(grant_valid), 32'd0);
    check("R1 enq_ready after drain", 32'(enq_ready), 32'd1);
  endtask

  // Cap zero: no batching; hit, rank and age ordering
  task automatic test_bypass_order;
    int order[5] = '{1, 0, 4, 3, 2};
    mark_cap   = 3'd0;
    bank_ready = 4'h0;
    bank_open_valid = 4'b0001;
    bank_open_row   = 32'h0000_0004;
    enq(1, 0, 7);
    enq(0, 0, 4);
    enq(3, 1, 9);
    enq(2, 1, 9);
    enq(1, 2, 1);
    @(negedge clk);
    bank_ready = 4'hF;
    #1;
    check("R2 no batch with cap zero", 32'(batch_active), 32'd0);
    expect_grant("R2 R6 row hit beats rank", order[0]);
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      #1;
      expect_grant("R2 R6 rank then age order", order[k]);
      check("R2 batch stays off", 32'(batch_active), 32'd0);
    end
    @(negedge clk);
    #1;
    check("R9 nothing left to grant", 32'(grant_valid), 32'd0);
  endtask

  // Late arrivals, work conservation and bank readiness
  task automatic test_late_and_conserve;
    mark_cap   = 3'd0;
    bank_ready = 4'h0;
    bank_open_valid = 4'b0001;
    bank_open_row   = 32'h0000_0001;
    enq(0, 0, 3);
    enq(1, 1, 2);
    @(negedge clk);
    mark_cap = 3'd1;
    @(negedge clk);
    #1;
    check("R3 batch formed for two requests", 32'(batch_active), 32'd1);
    enq(2, 0, 1);
    enq(3, 2, 5);
    @(negedge clk);
    bank_ready = 4'b0101;
    #1;
    expect_grant("R4 tagged beats late row hit", 0);
    @(negedge clk);
    #1;
    expect_grant("R4 late request once bank has no tag", 2);
    @(negedge clk);
    #1;
    expect_grant("R7 untagged served at free bank", 3);
    check("R7 batch still active", 32'(batch_active), 32'd1);
    @(negedge clk);
    #1;
    check("R8 no grant while bank busy", 32'(grant_valid), 32'd0);
    check("R8 tagged request still pending", 32'(batch_active), 32'd1);
    @(negedge clk);
    bank_ready = 4'hF;
    #1;
    expect_grant("R8 granted once bank ready", 1);
    @(negedge clk);
    #1;
    check("R9 empty after last grant", 32'(grant_valid), 32'd0);
    check("R3 batch ends when tags served", 32'(batch_active), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_batch_rank();
    test_bypass_order();
    test_late_and_conserve();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule